// File: doc/BRIEF.md
# Self-Normalizing Left Shifter

This block takes a 32-bit word and shifts it left until its highest set bit sits in the top position. It returns the shifted word, the number of positions moved (the leading-zero count, 5 bits wide) and a flag that marks an all-zero input. It is the normalization step used after a floating-point add or subtract. Rounding and exponent handling belong to the surrounding datapath.

The block has no separate leading-one detector. It is built as a cascade of shift levels, and the first level moves the word by the largest amount. Each level inspects the top bits of the word it receives. If all of them are zero, it shifts by its own amount; otherwise it passes the word through unchanged. The decision each level takes is one bit of the count. A parameter places a register after every level, so that the word, the partial count, the zero flag and a valid bit advance together. Without the registers the whole path is combinational.

Top module: `norm_shift`

## Requirements
- R1: For every valid input that is not zero, bit 31 of `out_data` is 1.
- R2: `out_count` equals the number of zeros above the highest set bit of the input, and `out_data` equals the input shifted left by `out_count`.
- R3: Positions vacated by the shift are filled with zeros: the lowest `out_count` bits of `out_data` are 0.
- R4: An all-zero input gives `out_zero` = 1, `out_data` = 0 and `out_count` = 31.
- R5: `out_zero` is 0 for every nonzero input.
- R6: With `PIPELINE` = 1, a result appears exactly 5 clock cycles after its input, together with `out_valid`, and a new input is accepted every cycle. With `PIPELINE` = 0, the result and `out_valid` follow the input within the same cycle.
- R7: While reset is asserted, and right after it, the pipelined variant drives `out_valid` low. Reset is active low and asynchronous.
- R8: An input whose bit 31 is already set comes out unchanged, with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional level registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as a word to normalize |
| in_data | input | 32 | Word to normalize |
| out_valid | output | 1 | Marks the outputs as a result |
| out_data | output | 32 | Normalized word |
| out_count | output | 5 | Left-shift amount (leading zeros) |
| out_zero | output | 1 | Input was all zeros |

## Verification
A wrong decision at any level shows at the ports in the same result. The top bit of `out_data` is then clear for a nonzero input, or the word no longer equals the input shifted by the reported count. A count bit that is placed at the wrong position gives the same kind of mismatch. A stage whose valid, flag or count register falls out of step with its data register shows up as results that appear one cycle early or late, or that are paired with a neighbour's flag, on the first streamed vector that follows. Inputs with no leading zeros, with a single set bit at the bottom, and with all zeros drive each level to both of its decisions.

// File: rtl/norm_shift.sv
module norm_shift #(
  parameter int WIDTH    = 32,
  parameter bit PIPELINE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [WIDTH-1:0]           in_data,
  output logic                       out_valid,
  output logic [WIDTH-1:0]           out_data,
  output logic [$clog2(WIDTH)-1:0]   out_count,
  output logic                       out_zero
);
  localparam int LEVELS = $clog2(WIDTH);

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    localparam int SH = 1 << (LEVELS - 1 - i);

    logic [WIDTH-1:0]  d_i, d_n, d_o;
    logic [LEVELS-1:0] c_i, c_n, c_o;
    logic              v_i, v_o, z_i, z_o;
    logic              take;

    if (i == 0) begin : g_src
      assign d_i = in_data;
      assign c_i = '0;
      assign v_i = in_valid;
      assign z_i = ~|in_data;
    end else begin : g_chain
      assign d_i = g_lvl[i-1].d_o;
      assign c_i = g_lvl[i-1].c_o;
      assign v_i = g_lvl[i-1].v_o;
      assign z_i = g_lvl[i-1].z_o;
    end

    assign take = ~|d_i[WIDTH-1 -: SH];
    assign d_n  = take ? (d_i << SH) : d_i;

    always_comb begin
      c_n = c_i;
      c_n[LEVELS-1-i] = take;
    end

    if (PIPELINE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_o <= '0;
          c_o <= '0;
          v_o <= 1'b0;
          z_o <= 1'b0;
        end else begin
          d_o <= d_n;
          c_o <= c_n;
          v_o <= v_i;
          z_o <= z_i;
        end
      end
    end else begin : g_wire
      assign d_o = d_n;
      assign c_o = c_n;
      assign v_o = v_i;
      assign z_o = z_i;
    end
  end

  assign out_data  = g_lvl[LEVELS-1].d_o;
  assign out_count = g_lvl[LEVELS-1].c_o;
  assign out_valid = g_lvl[LEVELS-1].v_o;
  assign out_zero  = g_lvl[LEVELS-1].z_o;
endmodule

// File: rtl/norm_shift_chk.sv
module norm_shift_chk #(
  parameter int WIDTH    = 32,
  parameter bit PIPELINE = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     out_valid,
  input logic [WIDTH-1:0]         out_data,
  input logic [$clog2(WIDTH)-1:0] out_count,
  input logic                     out_zero
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_msb_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_data[WIDTH-1]);

  assert_low_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ((ONE << out_count) - ONE)) == '0));

  assert_zero_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_data == '0 && out_count == '1));

  assert_flag_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data == '0) |-> out_zero);
endmodule

bind norm_shift norm_shift_chk #(.WIDTH(WIDTH), .PIPELINE(PIPELINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_data(out_data),
  .out_count(out_count), .out_zero(out_zero));

// File: tb/test_norm_shift.sv
module test_norm_shift;
  localparam int W = 32;
  localparam int L = 5;
  localparam int N = 13;
  localparam logic [63:0] VEC [N] = '{
    {32'h8000_0000, 32'd0},  {32'hFFFF_FFFF, 32'd0},  {32'h0000_0001, 32'd31},
    {32'h0001_0000, 32'd15}, {32'h4000_0000, 32'd1},  {32'h00FF_0000, 32'd8},
    {32'h0000_8000, 32'd16}, {32'h1234_5678, 32'd3},  {32'h0000_0F00, 32'd20},
    {32'h0000_0003, 32'd30}, {32'h0000_00A5, 32'd24}, {32'h0002_0001, 32'd14},
    {32'h0040_0000, 32'd9}
  };

  logic clk = 1'b0;
  logic rst_n, in_valid;
  logic [W-1:0] in_data;
  logic p_valid, c_valid, p_zero, c_zero;
  logic [W-1:0] p_data, c_data;
  logic [L-1:0] p_count, c_count;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  norm_shift #(.WIDTH(W), .PIPELINE(1'b1)) i_norm_shift (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(p_valid), .out_data(p_data), .out_count(p_count), .out_zero(p_zero));

  norm_shift #(.WIDTH(W), .PIPELINE(1'b0)) i_norm_shift_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(c_valid), .out_data(c_data), .out_count(c_count), .out_zero(c_zero));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_clz(input logic [W-1:0] x);
    for (int b = W - 1; b >= 0; b--) if (x[b]) return W - 1 - b;
    return W - 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 32'(p_valid), 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < N + L; k++) begin
      @(negedge clk);
      if (k >= L) begin
        chk("R6 pipe valid", 32'(p_valid), 32'd1);
        chk("R2 pipe data", p_data, VEC[k-L][63:32] << VEC[k-L][31:0]);
        chk("R2 pipe count", 32'(p_count), VEC[k-L][31:0]);
        chk("R5 pipe zero", 32'(p_zero), 32'd0);
      end else if (k < L) begin
        chk("R6 pipe not yet valid", 32'(p_valid), 32'd0);
      end
      if (k < N) begin
        in_valid = 1'b1; in_data = VEC[k][63:32];
        #1;
        chk("R6 comb valid", 32'(c_valid), 32'd1);
        chk("R2 comb count", 32'(c_count), VEC[k][31:0]);
        chk("R1 comb msb", 32'(c_data[W-1]), 32'd1);
        chk("R3 comb low fill", c_data & ((32'd1 << c_count) - 32'd1), 32'd0);
        if (VEC[k][31:0] == 0) chk("R8 unchanged", c_data, VEC[k][63:32]);
      end else begin
        in_valid = 1'b0; in_data = '0;
      end
    end
    @(negedge clk);
    chk("R6 pipe drained", 32'(p_valid), 32'd0);

    in_valid = 1'b1; in_data = '0;
    #1;
    chk("R4 comb zero flag", 32'(c_zero), 32'd1);
    chk("R4 comb data", c_data, 32'd0);
    chk("R4 comb count", 32'(c_count), 32'd31);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (L - 1) @(negedge clk);
    chk("R4 pipe valid", 32'(p_valid), 32'd1);
    chk("R4 pipe zero flag", 32'(p_zero), 32'd1);
    chk("R4 pipe data", p_data, 32'd0);
    chk("R4 pipe count", 32'(p_count), 32'd31);

    lfsr = 32'hACE1_2468;
    for (int j = 0; j < 64; j++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      in_valid = 1'b1; in_data = (lfsr >> (j % 32)) | 32'd1;
      #1;
      chk("R2 lfsr count", 32'(c_count), 32'(ref_clz(in_data)));
      chk("R2 lfsr data", c_data, in_data << ref_clz(in_data));
      chk("R1 lfsr msb", 32'(c_data[W-1]), 32'd1);
      chk("R5 lfsr zero", 32'(c_zero), 32'd0);
      @(negedge clk);
    end

    in_valid = 1'b1; in_data = 32'h0000_0100;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 async reset valid", 32'(p_valid), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after reset valid", 32'(p_valid), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule